// File: doc/BRIEF.md
# Speculative Load Address Check Table

This block keeps track of loads that the compiler moved ahead of stores that might write the same bytes. When such an early load issues, it records its destination register tag, its address and its access size in a small fully associative table. Every store then searches all entries at once and invalidates each entry whose byte range overlaps the stored bytes. Later, at the point where the load originally sat, a check operation looks up the entry for its register. The check passes only when a valid entry with that tag exists. If it fails, the pipeline must branch to recovery code.

The table has three independent request ports that all act in the same cycle: insert, store snoop and check. A check may also ask for its entry to be dropped once the lookup is done. A flush input empties the whole table in one cycle. The table picks the slot for a new load in this order: an entry that already holds the same register, then the lowest free slot, then a round-robin victim when the table is full.

Top module: `spec_ld_table`

## Requirements
- R1: After reset every entry is invalid, `chk_resp_valid_o` is low, and a check of any tag fails.
- R2: An insert followed by a check of the same tag passes. Each check issued in cycle t has its result (`chk_resp_valid_o` high, `chk_pass_o`) in cycle t+1.
- R3: A check of a tag that has no valid entry fails (`chk_resp_valid_o` high, `chk_pass_o` low).
- R4: A store whose byte range overlaps the range of an entry invalidates that entry. Size code s (0 to 3) means 2^s bytes (1, 2, 4 or 8). The range is addr to addr+2^s-1, taken without wrap-around.
- R5: A store whose byte range does not overlap an entry leaves that entry valid.
- R6: An insert for a tag that already has a valid entry overwrites that entry with the new address and size, so only the new range is matched afterwards.
- R7: When no valid entry holds the tag, an insert takes the lowest-index free entry. If all entries are valid, it replaces the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one, modulo the entry count, only on such a replacement.
- R8: A check with `chk_clear_i` set reports its result from the table as it was before the check and then invalidates the entry. A check without the clear flag leaves the entry in place.
- R9: When a store and an insert occur in the same cycle, the newly inserted entry is valid afterwards even if the store overlaps it. The store still invalidates other overlapping entries.
- R10: `flush_i` invalidates every entry in one cycle and overrides an insert in the same cycle.
- R11: A check sees the table as it was before any store, insert or flush in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| ins_valid_i | input | 1 | Early load insert request |
| ins_tag_i | input | 7 | Destination register tag of the load |
| ins_addr_i | input | 32 | Load byte address |
| ins_size_i | input | 2 | Load size code (2^code bytes) |
| st_valid_i | input | 1 | Store snoop request |
| st_addr_i | input | 32 | Store byte address |
| st_size_i | input | 2 | Store size code (2^code bytes) |
| chk_valid_i | input | 1 | Check lookup request |
| chk_tag_i | input | 7 | Register tag to check |
| chk_clear_i | input | 1 | Invalidate the entry after the lookup |
| chk_resp_valid_o | output | 1 | Check result valid (one cycle after request) |
| chk_pass_o | output | 1 | Check passed; low with valid means recovery is needed |

## Verification
Directed sequences separate the overlap cases from each other: a store touching the last byte of the load range, a store touching only the first byte past it, and the old address of a register whose entry was overwritten. Same-cycle collisions of store with insert, of check with store, and of flush with insert tell the update priorities apart. A fill of all entries followed by more inserts, with one slot freed by a clearing check along the way, tells free-slot allocation apart from round-robin replacement. Random mixes of all four ports over a narrow tag and address window then compare every check result against a bench model of the table.

// File: rtl/spec_ld_pkg.sv
package spec_ld_pkg;
  parameter int unsigned ENTRIES = 16;
  parameter int unsigned TAG_W   = 7;
  parameter int unsigned ADDR_W  = 32;
  parameter int unsigned SIZE_W  = 2;
  localparam int unsigned IDX_W  = $clog2(ENTRIES);

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] addr;
    logic [SIZE_W-1:0] size;
  } ld_rec_t;
endpackage

// File: rtl/spec_ld_overlap.sv
module spec_ld_overlap #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 2
) (
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [SIZE_W-1:0] a_size,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [SIZE_W-1:0] b_size,
  output logic              overlap
);
  localparam int unsigned EW = ADDR_W + 1;
  logic [EW-1:0] a_lo, a_hi, b_lo, b_hi;

  always_comb begin
    a_lo = {1'b0, a_addr};
    b_lo = {1'b0, b_addr};
    a_hi = a_lo + (EW'(1) << a_size) - EW'(1);
    b_hi = b_lo + (EW'(1) << b_size) - EW'(1);
    overlap = (a_lo <= b_hi) && (b_lo <= a_hi);
  end
endmodule

// File: rtl/spec_ld_alloc.sv
module spec_ld_alloc #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] tag_hit_vec,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [ENTRIES-1:0] write_vec,
  output logic               replace
);
  logic [ENTRIES-1:0] free_pick;
  logic               found;

  always_comb begin
    free_pick = '0;
    found     = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_vec[i] && !found) begin
        free_pick[i] = 1'b1;
        found        = 1'b1;
      end
    end
    replace = 1'b0;
    if (|tag_hit_vec) begin
      write_vec = tag_hit_vec;
    end else if (found) begin
      write_vec = free_pick;
    end else begin
      write_vec = '0;
      write_vec[rr_ptr] = 1'b1;
      replace = 1'b1;
    end
  end
endmodule

// File: rtl/spec_ld_table.sv
module spec_ld_table
  import spec_ld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              ins_valid_i,
  input  logic [TAG_W-1:0]  ins_tag_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic [SIZE_W-1:0] ins_size_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [SIZE_W-1:0] st_size_i,
  input  logic              chk_valid_i,
  input  logic [TAG_W-1:0]  chk_tag_i,
  input  logic              chk_clear_i,
  output logic              chk_resp_valid_o,
  output logic              chk_pass_o
);
  ld_rec_t            rec_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [IDX_W-1:0]   rr_q, rr_d;
  logic               resp_d, pass_d;

  logic [ENTRIES-1:0] st_hit, ins_tag_hit, chk_hit, ins_write;
  logic               ins_replace;
  logic [ENTRIES-1:0] wr_en;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    spec_ld_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ovl (
      .a_addr (rec_q[g].addr),
      .a_size (rec_q[g].size),
      .b_addr (st_addr_i),
      .b_size (st_size_i),
      .overlap(st_hit[g])
    );
    assign ins_tag_hit[g] = valid_q[g] && (rec_q[g].tag == ins_tag_i);
    assign chk_hit[g]     = valid_q[g] && (rec_q[g].tag == chk_tag_i);
    assign wr_en[g]       = ins_valid_i && !flush_i && ins_write[g];

    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        rec_q[g] <= '{tag: ins_tag_i, addr: ins_addr_i, size: ins_size_i};
      end
    end

    // R4 / R9: an overlapping store drops the entry unless it is rewritten
    a_r4_store_kills: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid_i && valid_q[g] && st_hit[g] && !wr_en[g] |=> !valid_q[g]);
    // R9: the insert wins over a same-cycle store
    a_r9_insert_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[g] |=> valid_q[g]);
  end

  spec_ld_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .valid_vec  (valid_q),
    .tag_hit_vec(ins_tag_hit),
    .rr_ptr     (rr_q),
    .write_vec  (ins_write),
    .replace    (ins_replace)
  );

  always_comb begin
    valid_d = valid_q;
    if (chk_valid_i && chk_clear_i) valid_d = valid_d & ~chk_hit;
    if (st_valid_i)                 valid_d = valid_d & ~(st_hit & valid_q);
    valid_d = valid_d | wr_en;
    if (flush_i)                    valid_d = '0;

    rr_d = rr_q;
    if (ins_valid_i && !flush_i && ins_replace) begin
      rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
    end

    resp_d = chk_valid_i;
    pass_d = chk_valid_i && (|chk_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q          <= '0;
      rr_q             <= '0;
      chk_resp_valid_o <= 1'b0;
      chk_pass_o       <= 1'b0;
    end else begin
      valid_q          <= valid_d;
      rr_q             <= rr_d;
      chk_resp_valid_o <= resp_d;
      chk_pass_o       <= pass_d;
    end
  end

  // R6: at most one valid entry can match a tag
  a_r6_tag_unique: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_i |-> $onehot0(chk_hit));
  // R2: every check request gets a result in the next cycle
  a_r2_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_i |=> chk_resp_valid_o);
  // R3: a pass is only reported together with a result
  a_r3_pass_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    chk_pass_o |-> chk_resp_valid_o);
  // R10: a flush empties the table
  a_r10_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_q == '0));
  // R7: the insert port writes exactly one entry
  a_r7_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid_i && !flush_i |-> $countones(wr_en) == 1);
endmodule

// File: tb/spec_ld_table_tb.sv
`timescale 1ns/1ps
module spec_ld_table_tb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic        ins_valid_i = 1'b0;
  logic [6:0]  ins_tag_i = '0;
  logic [31:0] ins_addr_i = '0;
  logic [1:0]  ins_size_i = '0;
  logic        st_valid_i = 1'b0;
  logic [31:0] st_addr_i = '0;
  logic [1:0]  st_size_i = '0;
  logic        chk_valid_i = 1'b0;
  logic [6:0]  chk_tag_i = '0;
  logic        chk_clear_i = 1'b0;
  logic        chk_resp_valid_o, chk_pass_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  bit        m_valid [N];
  bit [6:0]  m_tag   [N];
  bit [31:0] m_addr  [N];
  bit [1:0]  m_size  [N];
  int        m_rr;

  always #2 clk = ~clk;

  spec_ld_table u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .ins_valid_i(ins_valid_i), .ins_tag_i(ins_tag_i),
    .ins_addr_i(ins_addr_i), .ins_size_i(ins_size_i),
    .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_size_i(st_size_i),
    .chk_valid_i(chk_valid_i), .chk_tag_i(chk_tag_i), .chk_clear_i(chk_clear_i),
    .chk_resp_valid_o(chk_resp_valid_o), .chk_pass_o(chk_pass_o)
  );

  function automatic bit f_overlap(bit [31:0] a, bit [1:0] sa, bit [31:0] b, bit [1:0] sb);
    longint alo = longint'(a), blo = longint'(b);
    longint ahi = alo + (longint'(1) << sa) - 1;
    longint bhi = blo + (longint'(1) << sb) - 1;
    return (alo <= bhi) && (blo <= ahi);
  endfunction

  function automatic int f_find(bit [6:0] t);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic int f_free();
    for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
    return -1;
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus; called at a falling edge, returns at the next one
  task automatic step(bit iv, bit [6:0] it, bit [31:0] ia, bit [1:0] is,
                      bit sv, bit [31:0] sa, bit [1:0] ss,
                      bit cv, bit [6:0] ct, bit cc, bit fl, string req);
    bit exp_pass;
    bit nv [N];
    int ci, tgt;
    ins_valid_i = iv; ins_tag_i = it; ins_addr_i = ia; ins_size_i = is;
    st_valid_i = sv; st_addr_i = sa; st_size_i = ss;
    chk_valid_i = cv; chk_tag_i = ct; chk_clear_i = cc; flush_i = fl;
    ci = f_find(ct);
    exp_pass = (ci >= 0);
    @(posedge clk);
    // model update from pre-state (R8 R9 R10 R11 ordering)
    for (int i = 0; i < N; i++) begin
      nv[i] = m_valid[i];
      if (cv && cc && i == ci) nv[i] = 1'b0;
      if (sv && m_valid[i] && f_overlap(m_addr[i], m_size[i], sa, ss)) nv[i] = 1'b0;
    end
    if (iv && !fl) begin
      tgt = f_find(it);
      if (tgt < 0) tgt = f_free();
      if (tgt < 0) begin
        tgt = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      nv[tgt] = 1'b1; m_tag[tgt] = it; m_addr[tgt] = ia; m_size[tgt] = is;
    end
    for (int i = 0; i < N; i++) m_valid[i] = fl ? 1'b0 : nv[i];
    @(negedge clk);
    if (cv) begin
      check(chk_resp_valid_o == 1'b1, {req, " resp_valid"}, chk_resp_valid_o, 1);
      check(chk_pass_o == exp_pass, {req, " pass"}, chk_pass_o, exp_pass);
    end else begin
      check(chk_resp_valid_o == 1'b0, {req, " idle"}, chk_resp_valid_o, 0);
    end
    ins_valid_i = 0; st_valid_i = 0; chk_valid_i = 0; chk_clear_i = 0; flush_i = 0;
  endtask

  task automatic ins(bit [6:0] t, bit [31:0] a, bit [1:0] s, string req);
    step(1, t, a, s, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic st(bit [31:0] a, bit [1:0] s, string req);
    step(0, 0, 0, 0, 1, a, s, 0, 0, 0, 0, req);
  endtask
  task automatic chk(bit [6:0] t, bit clr, string req);
    step(0, 0, 0, 0, 0, 0, 0, 1, t, clr, 0, req);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
    m_rr = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(chk_resp_valid_o == 1'b0, "R1 resp after reset", chk_resp_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(7'd5, 0, "R1 R3 empty table");
    // R2 insert then check
    ins(7'd5, 32'h100, 2'd2, "R2 insert");
    chk(7'd5, 0, "R2 hit");
    chk(7'd6, 0, "R3 other tag");
    // R5 store just past the range
    st(32'h104, 2'd0, "R5 store");
    chk(7'd5, 0, "R5 survives");
    st(32'h0F8, 2'd3, "R5 store below");
    chk(7'd5, 0, "R5 survives below");
    // R4 store on last byte
    st(32'h103, 2'd0, "R4 store");
    chk(7'd5, 0, "R4 killed");
    // R6 overwrite
    ins(7'd5, 32'h200, 2'd3, "R6 first");
    ins(7'd5, 32'h300, 2'd0, "R6 second");
    st(32'h200, 2'd3, "R6 old addr store");
    chk(7'd5, 0, "R6 still valid");
    st(32'h2FE, 2'd2, "R6 new addr store");
    chk(7'd5, 0, "R6 new addr killed");
    // R8 clear flag
    ins(7'd5, 32'h500, 2'd1, "R8 insert");
    chk(7'd5, 1, "R8 clear check passes");
    chk(7'd5, 0, "R8 gone after clear");
    // R9 store and insert same cycle
    ins(7'd8, 32'h400, 2'd1, "R9 other entry");
    step(1, 7'd9, 32'h400, 2'd2, 1, 32'h401, 2'd0, 0, 0, 0, 0, "R9 collide");
    chk(7'd9, 0, "R9 insert wins");
    chk(7'd8, 0, "R9 store kills other");
    // R11 check sees pre-store state
    step(0, 0, 0, 0, 1, 32'h400, 2'd0, 1, 7'd9, 0, 0, "R11 check with store");
    chk(7'd9, 0, "R11 killed after");
    step(1, 7'd12, 32'h700, 2'd0, 0, 0, 0, 1, 7'd12, 0, 0, "R11 check with insert");
    // R10 flush
    ins(7'd13, 32'h800, 2'd0, "R10 fill");
    step(1, 7'd14, 32'h900, 2'd0, 0, 0, 0, 0, 0, 0, 1, "R10 flush+insert");
    chk(7'd12, 0, "R10 flushed");
    chk(7'd14, 0, "R10 insert dropped");
    // R7 fill and round-robin
    for (int i = 0; i < N; i++) ins(7'(20 + i), 32'h1000 + 32'(i * 16), 2'd0, "R7 fill");
    ins(7'd40, 32'h2000, 2'd0, "R7 replace0");
    chk(7'd20, 0, "R7 victim0");
    chk(7'd21, 0, "R7 entry1 kept");
    ins(7'd41, 32'h2010, 2'd0, "R7 replace1");
    chk(7'd21, 0, "R7 victim1");
    chk(7'd25, 1, "R7 free slot");
    ins(7'd42, 32'h2020, 2'd0, "R7 uses free");
    chk(7'd22, 0, "R7 no rr advance");
    ins(7'd43, 32'h2030, 2'd0, "R7 replace2");
    chk(7'd22, 0, "R7 victim2");
    chk(7'd42, 0, "R7 free slot held");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      bit iv = ($urandom % 3) == 0;
      bit sv = ($urandom % 3) == 0;
      bit cv = ($urandom % 2) == 0;
      bit fl = ($urandom % 97) == 0;
      step(iv, 7'($urandom % 24), 32'h1000 + ($urandom % 64), 2'($urandom),
           sv, 32'h1000 + ($urandom % 64), 2'($urandom),
           cv, 7'($urandom % 24), ($urandom % 4) == 0, fl, "R2 R4 R7 random");
    end
    finish_run();
  end
endmodule